// File: doc/BRIEF.md
# Instruction Register and Dispatch Unit

This block keeps the 16-bit instruction word of the machine that a microcoded CPU emulates. It serves the microcode requests tied to that word. One request loads the word from the processor bus, and in the same cycle it returns a branch offset taken from the incoming word. Other requests replace the accumulator bits of the register-file address with a field of the stored word. A dispatch request produces a multi-way branch offset, which the sequencer ORs into its next microaddress. A separate bus-source request puts the displacement byte on the bus, either zero-extended or sign-extended.

Bit numbering follows the machine convention: bit 0 of a word is its most significant bit. So instruction bit k is vector index 15-k. In the same way, bit k of the 5-bit register select is index 4-k. The dispatch lookup table is a parameter of 256 entries of 4 bits. It is read combinationally, and the integrating design or the testbench fills it. A request code chooses the microcode function for each cycle: 0 none, 1 load, 2 dispatch, 3 accumulator source, 4 accumulator destination, 5 shift destination. Codes 6 and 7 act as none.

Top module: `ir_dispatch_unit`

## Requirements
- R1: Reset is synchronous and active-low. It clears the instruction word to zero and forces the skip-clear pulse low. A load request made while reset is low has no effect.
- R2: With request code 1 (load), the instruction word takes the value of `bus_in` at the rising clock edge. No other code changes the stored word.
- R3: `skip_clr` is high for exactly the one cycle that follows a cycle with request code 1. It is low in every other cycle.
- R4: During a load request, `branch_out` equals {bus bit 0, bus bits 5, 6, 7}, with bus bit 0 as the most significant bit. Bus bit k is `bus_in[15-k]`. The offset is formed in the same cycle as the request.
- R5: With code 3 (accumulator source), `rsel_out[1:0]` equals the complement of instruction bits 1–2 (`ir[14:13]`). `rsel_out[4:2]` equals `rsel_in[4:2]`.
- R6: With code 4 (accumulator destination) and with code 5 (shift destination), `rsel_out[1:0]` equals the complement of instruction bits 3–4 (`ir[12:11]`). The upper three bits pass through unchanged.
- R7: With any other request code, `rsel_out` equals `rsel_in`.
- R8: When `disp_rd` is high and the index field (instruction bits 6–7, `ir[9:8]`) is zero, `disp_out` is {8'h00, instruction bits 8–15}.
- R9: When `disp_rd` is high and the index field is non-zero, the upper byte of `disp_out` copies instruction bit 8 (`ir[7]`).
- R10: With code 2 or code 3, if instruction bit 0 is set, `branch_out` is {2'b00, complement of the shift field}. The shift field is instruction bits 8–9, `ir[7:6]`.
- R11: With code 2 or code 3, if instruction bit 0 is clear, `branch_out` is the table entry at address {code==2, `ir[14:8]`}. Entry a occupies `DISPATCH_TABLE[4a+3:4a]`.
- R12: `branch_out` is zero for codes 0, 4, 5, 6 and 7. `disp_out` is zero while `disp_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| req_code | input | 3 | Microcode request for this cycle |
| disp_rd | input | 1 | Displacement bus-source request |
| bus_in | input | 16 | Processor bus value, used by the load request |
| rsel_in | input | 5 | Register select from the microinstruction |
| rsel_out | output | 5 | Register select after accumulator override |
| branch_out | output | 4 | Branch bits ORed into the next microaddress |
| disp_out | output | 16 | Displacement word for the bus |
| skip_clr | output | 1 | One-cycle pulse that clears the skip latch |

## Verification
The branch offset, the register-select override and the displacement are combinational. Each is due in the same cycle as its request. The bench therefore drives each request just after a falling edge and samples one time unit later, before the next rising edge. A loaded word becomes visible only after the rising edge of its load cycle. The skip-clear pulse is registered, so it is due in the cycle after the load. The bench samples it at the following falling edge and checks that it is low again one cycle later. The sweep covers every value of the instruction's upper byte, together with eight lower bytes, and checks every request code against each word.

// File: rtl/irdu_pkg.sv
// Package irdu_pkg
// Shared widths and the request encoding for the instruction dispatch unit.
// Assumes machine bit 0 is the most significant bit of every word.
package irdu_pkg;

    localparam int WORD_W  = 16;
    localparam int SEL_W   = 5;
    localparam int BR_W    = 4;
    localparam int TBL_AW  = 8;
    localparam int TBL_N   = 1 << TBL_AW;
    localparam int TBL_W   = TBL_N * BR_W;
    localparam int BYTE_W  = WORD_W / 2;

    typedef enum logic [2:0] {
        REQ_NONE     = 3'd0,
        REQ_LOAD     = 3'd1,
        REQ_DISPATCH = 3'd2,
        REQ_AC_SRC   = 3'd3,
        REQ_AC_DST   = 3'd4,
        REQ_SHIFT    = 3'd5
    } req_e;

endpackage

// File: rtl/irdu_word_store.sv
// Module irdu_word_store
// Holds the instruction word and creates the one-cycle skip-clear pulse
// that follows every load. Assumes a synchronous active-low reset.
module irdu_word_store
    import irdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  req_e              req,
    input  logic [WORD_W-1:0] bus_in,
    output logic [WORD_W-1:0] ir_q,
    output logic              skip_clr
);

    // Capture the bus word on a load request; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (req == REQ_LOAD) begin
            ir_q <= bus_in;
        end
    end

    // Raise the skip-clear pulse for the single cycle after a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skip_clr <= 1'b0;
        end else begin
            skip_clr <= (req == REQ_LOAD);
        end
    end

    p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req == REQ_LOAD) |=> (ir_q == $past(bus_in)));

    p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req != REQ_LOAD) |=> $stable(ir_q));

    p_skip_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req == REQ_LOAD) |=> skip_clr);

    p_skip_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req != REQ_LOAD) |=> !skip_clr);

endmodule

// File: rtl/irdu_sel_override.sv
// Module irdu_sel_override
// Replaces the two accumulator bits of the register select with the
// source or destination field of the instruction word. The word holds
// these fields complemented, so they are inverted on the way out.
module irdu_sel_override
    import irdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  req_e              req,
    input  logic [WORD_W-1:0] ir_q,
    input  logic [SEL_W-1:0]  rsel_in,
    output logic [SEL_W-1:0]  rsel_out
);

    localparam int AC_W = 2;

    logic [AC_W-1:0] src_ac;
    logic [AC_W-1:0] dst_ac;

    // Pick out instruction bits 1-2 (source) and 3-4 (destination), then invert them.
    always_comb begin
        src_ac = ~ir_q[WORD_W-2 -: AC_W];
        dst_ac = ~ir_q[WORD_W-4 -: AC_W];
    end

    // Put the selected field into the low select bits for the accumulator requests.
    always_comb begin
        rsel_out = rsel_in;
        unique case (req)
            REQ_AC_SRC:             rsel_out[AC_W-1:0] = src_ac;
            REQ_AC_DST, REQ_SHIFT:  rsel_out[AC_W-1:0] = dst_ac;
            default:                rsel_out = rsel_in;
        endcase
    end

    p_upper_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsel_out[SEL_W-1:AC_W] == rsel_in[SEL_W-1:AC_W]);

    p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req inside {REQ_AC_SRC, REQ_AC_DST, REQ_SHIFT}) |-> rsel_out == rsel_in);

endmodule

// File: rtl/irdu_disp_gen.sv
// Module irdu_disp_gen
// Builds the displacement word from the low byte of the instruction.
// An index field of zero means page-zero addressing, so the byte is
// zero-extended; any other index value sign-extends it.
module irdu_disp_gen
    import irdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_rd,
    input  logic [WORD_W-1:0] ir_q,
    output logic [WORD_W-1:0] disp_out
);

    localparam int IDX_LO = BYTE_W;
    localparam int IDX_W  = 2;

    logic [BYTE_W-1:0] low_byte;
    logic [IDX_W-1:0]  index_fld;
    logic [BYTE_W-1:0] high_byte;

    // Choose the fill for the upper byte from the index field.
    always_comb begin
        low_byte  = ir_q[BYTE_W-1:0];
        index_fld = ir_q[IDX_LO +: IDX_W];
        high_byte = (index_fld == '0) ? '0 : {BYTE_W{low_byte[BYTE_W-1]}};
    end

    // Drive the word only while the bus-source request is active.
    always_comb begin
        disp_out = disp_rd ? {high_byte, low_byte} : '0;
    end

    p_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_rd |-> disp_out == '0);

    p_sign_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_rd && ir_q[IDX_LO +: IDX_W] != '0)
            |-> disp_out[WORD_W-1:BYTE_W] == {BYTE_W{ir_q[BYTE_W-1]}});

    p_zero_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_rd && ir_q[IDX_LO +: IDX_W] == '0) |-> disp_out[WORD_W-1:BYTE_W] == '0);

endmodule

// File: rtl/irdu_branch_gen.sv
// Module irdu_branch_gen
// Forms the branch offset that the sequencer ORs into its next address.
// A load branches on bits 0 and 5-7 of the incoming bus word. A dispatch,
// or the late phase of an accumulator-source request, branches on the
// inverted shift field when bit 0 is set, and on a table entry otherwise.
module irdu_branch_gen
    import irdu_pkg::*;
#(
    parameter logic [TBL_W-1:0] DISPATCH_TABLE = '0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  req_e              req,
    input  logic [WORD_W-1:0] bus_in,
    input  logic [WORD_W-1:0] ir_q,
    output logic [BR_W-1:0]   branch_out
);

    localparam int SH_W  = 2;
    localparam int OPC_W = TBL_AW - 1;

    logic [BR_W-1:0]   load_br;
    logic [BR_W-1:0]   arith_br;
    logic [TBL_AW-1:0] tbl_addr;
    logic [BR_W-1:0]   tbl_br;
    logic              arith;

    // Offset for a load: bus bit 0 on top, then bus bits 5-7.
    always_comb begin
        load_br = {bus_in[WORD_W-1], bus_in[WORD_W-6 -: BR_W-1]};
    end

    // Offset for an arithmetic word: the inverted shift field (bits 8-9).
    always_comb begin
        arith    = ir_q[WORD_W-1];
        arith_br = {{(BR_W-SH_W){1'b0}}, ~ir_q[BYTE_W-1 -: SH_W]};
    end

    // Table read: the top address bit marks the dispatch request.
    always_comb begin
        tbl_addr = {(req == REQ_DISPATCH), ir_q[WORD_W-2 -: OPC_W]};
        tbl_br   = DISPATCH_TABLE[int'(tbl_addr)*BR_W +: BR_W];
    end

    // Select the offset that belongs to this cycle's request.
    always_comb begin
        unique case (req)
            REQ_LOAD:                 branch_out = load_br;
            REQ_DISPATCH, REQ_AC_SRC: branch_out = arith ? arith_br : tbl_br;
            default:                  branch_out = '0;
        endcase
    end

    p_arith_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((req == REQ_DISPATCH || req == REQ_AC_SRC) && ir_q[WORD_W-1])
            |-> branch_out[BR_W-1:SH_W] == '0);

    p_load_top_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req == REQ_LOAD) |-> branch_out[BR_W-1] == bus_in[WORD_W-1]);

    p_quiet_codes_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(req inside {REQ_LOAD, REQ_DISPATCH, REQ_AC_SRC}) |-> branch_out == '0);

endmodule

// File: rtl/ir_dispatch_unit.sv
// Module ir_dispatch_unit
// Top level: the instruction word store, the register-select override,
// the displacement source and the branch offset generator.
// Assumes one request code per cycle; codes 6 and 7 act as no request.
module ir_dispatch_unit
    import irdu_pkg::*;
#(
    parameter logic [TBL_W-1:0] DISPATCH_TABLE = '0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        req_code,
    input  logic              disp_rd,
    input  logic [WORD_W-1:0] bus_in,
    input  logic [SEL_W-1:0]  rsel_in,
    output logic [SEL_W-1:0]  rsel_out,
    output logic [BR_W-1:0]   branch_out,
    output logic [WORD_W-1:0] disp_out,
    output logic              skip_clr
);

    req_e              req;
    logic [WORD_W-1:0] ir_q;

    // Decode the raw request code; unused codes become no request.
    always_comb begin
        req = (req_code > 3'd5) ? REQ_NONE : req_e'(req_code);
    end

    irdu_word_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .bus_in   (bus_in),
        .ir_q     (ir_q),
        .skip_clr (skip_clr)
    );

    irdu_sel_override u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .ir_q     (ir_q),
        .rsel_in  (rsel_in),
        .rsel_out (rsel_out)
    );

    irdu_disp_gen u_disp (
        .clk      (clk),
        .rst_n    (rst_n),
        .disp_rd  (disp_rd),
        .ir_q     (ir_q),
        .disp_out (disp_out)
    );

    irdu_branch_gen #(
        .DISPATCH_TABLE (DISPATCH_TABLE)
    ) u_branch (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .bus_in     (bus_in),
        .ir_q       (ir_q),
        .branch_out (branch_out)
    );

endmodule

// File: tb/test_ir_dispatch_unit.sv
`timescale 1ns/1ps
module test_ir_dispatch_unit;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 256 * 4;

    // Test table entry: an arithmetic scramble of the address.
    function automatic logic [3:0] tbl_entry(input int a);
        return 4'((a * 5 + (a >> 3) + 1) & 15);
    endfunction

    function automatic logic [TW-1:0] build_table();
        logic [TW-1:0] t;
        t = '0;
        for (int a = 0; a < 256; a++) t[a*4 +: 4] = tbl_entry(a);
        return t;
    endfunction

    localparam logic [TW-1:0] TBL = build_table();

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  req_code = 3'd0;
    logic        disp_rd = 1'b0;
    logic [15:0] bus_in = '0;
    logic [4:0]  rsel_in = '0;
    logic [4:0]  rsel_out;
    logic [3:0]  branch_out;
    logic [15:0] disp_out;
    logic        skip_clr;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_dispatch_unit #(.DISPATCH_TABLE(TBL)) i_ir_dispatch_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_code   (req_code),
        .disp_rd    (disp_rd),
        .bus_in     (bus_in),
        .rsel_in    (rsel_in),
        .rsel_out   (rsel_out),
        .branch_out (branch_out),
        .disp_out   (disp_out),
        .skip_clr   (skip_clr)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_disp(input logic [15:0] w);
        if (w[9:8] == 2'b00) return {8'h00, w[7:0]};
        return {{8{w[7]}}, w[7:0]};
    endfunction

    function automatic logic [3:0] exp_dispatch(input logic [15:0] w, input logic is_disp);
        if (w[15]) return {2'b00, ~w[7:6]};
        return tbl_entry(int'({is_disp, w[14:8]}));
    endfunction

    // One instruction word through every request code.
    task automatic run_word(input logic [15:0] w, input logic [4:0] rs);
        @(negedge clk);
        req_code = 3'd1; bus_in = w; disp_rd = 1'b0; rsel_in = rs;
        #1;
        check("R4 load branch", {12'h0, branch_out}, {12'h0, w[15], w[10:8]});
        check("R12 disp idle", disp_out, 16'h0000);
        check("R7 rsel on load", {11'h0, rsel_out}, {11'h0, rs});
        @(negedge clk);
        check("R3 skip pulse", {15'h0, skip_clr}, 16'h0001);
        req_code = 3'd2; bus_in = ~w;
        #1;
        check("R10/R11 dispatch", {12'h0, branch_out}, {12'h0, exp_dispatch(w, 1'b1)});
        check("R7 rsel on dispatch", {11'h0, rsel_out}, {11'h0, rs});
        @(negedge clk);
        check("R3 skip low", {15'h0, skip_clr}, 16'h0000);
        req_code = 3'd3; disp_rd = 1'b1;
        #1;
        check("R5 rsel source", {11'h0, rsel_out}, {11'h0, rs[4:2], ~w[14:13]});
        check("R10/R11 source branch", {12'h0, branch_out}, {12'h0, exp_dispatch(w, 1'b0)});
        check("R2 R8 R9 displacement", disp_out, exp_disp(w));
        @(negedge clk);
        req_code = 3'd4; disp_rd = 1'b0;
        #1;
        check("R6 rsel dest", {11'h0, rsel_out}, {11'h0, rs[4:2], ~w[12:11]});
        check("R12 dest branch", {12'h0, branch_out}, 16'h0000);
        @(negedge clk);
        req_code = 3'd5;
        #1;
        check("R6 rsel shift", {11'h0, rsel_out}, {11'h0, rs[4:2], ~w[12:11]});
        check("R12 shift branch", {12'h0, branch_out}, 16'h0000);
        @(negedge clk);
        req_code = 3'd7; disp_rd = 1'b1;
        #1;
        check("R7 rsel unused code", {11'h0, rsel_out}, {11'h0, rs});
        check("R12 unused branch", {12'h0, branch_out}, 16'h0000);
        check("R2 word held", disp_out, exp_disp(w));
        req_code = 3'd0; disp_rd = 1'b0;
    endtask

    initial begin
        logic [7:0] lows [8];
        lows = '{8'h00, 8'h7F, 8'h80, 8'hC3, 8'hFF, 8'h41, 8'h9A, 8'h3C};
        // Reset with a load request present: the load must not take effect.
        req_code = 3'd1; bus_in = 16'hFFFF;
        repeat (3) @(negedge clk);
        req_code = 3'd0; disp_rd = 1'b1;
        #1;
        check("R1 reset word", disp_out, 16'h0000);
        check("R1 reset skip", {15'h0, skip_clr}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", disp_out, 16'h0000);
        disp_rd = 1'b0;

        for (int hi = 0; hi < 256; hi++) begin
            for (int k = 0; k < 8; k++) begin
                run_word({hi[7:0], lows[k]}, 5'((hi + k * 3) & 31));
            end
        end

        // Reset in mid-run clears the loaded word.
        run_word(16'hA5F3, 5'd9);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; disp_rd = 1'b1;
        #1;
        check("R1 mid-run reset", disp_out, 16'h0000);
        check("R1 skip after reset", {15'h0, skip_clr}, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule